// File: doc/BRIEF.md
# Synthesizer Channel Tuning Sequencer

This block takes a requested 2.4 GHz channel number and programs a dual RF/IF frequency synthesizer for it. On a start request it captures the channel and a divide-by-two option, and derives the RF frequency in MHz, the RF feedback divider, the reference divider and the loop gain bit. It then hands a fixed series of seven register words to a downstream serial register writer, one at a time, over a request/acknowledge handshake.

After the last word is taken, the block counts a settling interval of at least 100 µs in clock cycles so the loops can lock. It then pulses `done_o`. A channel number outside 1..14 produces an error pulse instead, and no word is issued. The bit-level serial protocol belongs to the downstream writer.

Top module: `chan_tune_seq`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o`, `err_o` and `wr_req_o` are all low.
- R2: A valid run issues exactly seven writes, with these addresses in this order: power 2, main 0, gain 1, IF N 5, IF R 8, RF2 R 7, RF2 N 4. The RF1 addresses (3 for N, 6 for R) are never written.
- R3: The RF2 N data equals the channel frequency minus 374. The frequency is 2484 MHz for channel 14 and 2407 + 5 × channel MHz for channels 1..13.
- R4: The IF R and RF2 R data are 88 when `xdiv2_i` was low at start, and 44 when it was high. The main-register data has bit 6 equal to that captured option and all other bits zero.
- R5: The gain-register data has bit 2 set exactly when the RF2 N value exceeds 2047, with all other bits zero.
- R6: The power-register data is 0x00003, which sets both power-down-bar bits (bit 1 for IF, bit 0 for RF). The IF N data is 1496.
- R7: A word is accepted on a rising clock edge where `wr_req_o` and `wr_ack_i` are both high. Until then, `wr_req_o` stays high and `wr_addr_o`/`wr_data_o` stay stable.
- R8: `done_o` is a single-cycle pulse. Its rising edge comes exactly CLK_MHZ × SETTLE_US clock edges after the edge that accepted the last write.
- R9: For channels 0 and 15, `err_o` pulses once, no write is requested and `done_o` stays low.
- R10: A start request while `busy_o` is high is ignored. The running sequence keeps its captured channel and option.
- R11: `busy_o` is high from the cycle after an accepted start until the end of its done or error pulse, then returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| chan_i | input | 4 | Requested channel number |
| xdiv2_i | input | 1 | Input divide-by-two option |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when tuning and settling finish |
| err_o | output | 1 | One-cycle pulse for an invalid channel |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | 4 | Synthesizer register address |
| wr_data_o | output | 18 | Synthesizer register data |
| wr_ack_i | input | 1 | Downstream writer accepts the current word |

## Verification
Every channel code from 0 to 15 is driven with the divide-by-two option both off and on. This separates the channel 14 special case from the linear formula, and the R = 44 words from the R = 88 words. The channels around the N = 2047 boundary (2 gives 2043, 3 gives 2048) show whether the gain bit flips at the right point. Codes 0 and 15 show that out-of-range channels are rejected. The acknowledge delay varies from word to word, which shows that words are held until taken. A second start injected mid-run with a different channel and option shows that a busy block ignores it.

// File: rtl/synth_tune_pkg.sv
package synth_tune_pkg;

    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 18;
    localparam int NUM_WRITES = 7;
    localparam int IDX_W      = $clog2(NUM_WRITES);

    // synthesizer register addresses
    localparam logic [ADDR_W-1:0] A_MAIN = 4'd0;
    localparam logic [ADDR_W-1:0] A_GAIN = 4'd1;
    localparam logic [ADDR_W-1:0] A_PWR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_RF1N = 4'd3;
    localparam logic [ADDR_W-1:0] A_RF2N = 4'd4;
    localparam logic [ADDR_W-1:0] A_IFN  = 4'd5;
    localparam logic [ADDR_W-1:0] A_RF1R = 4'd6;
    localparam logic [ADDR_W-1:0] A_RF2R = 4'd7;
    localparam logic [ADDR_W-1:0] A_IFR  = 4'd8;

    localparam int XIN_MHZ   = 44;
    localparam int IF_MHZ    = 374;
    localparam int KP2_LIMIT = 2047;
    localparam int CH_TOP    = 14;
    localparam int CH_TOP_MHZ = 2484;
    localparam int CH_BASE_MHZ = 2407;
    localparam int CH_STEP_MHZ = 5;

    localparam logic [DATA_W-1:0] PWR_WORD  = 18'h00003;
    localparam logic [DATA_W-1:0] IFN_WORD  = 18'd1496;
    localparam int                MAIN_XDIV_BIT = 6;
    localparam int                GAIN_KP2_BIT  = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_word_t;

    typedef struct packed {
        logic        valid;
        logic [11:0] rf_n;
        logic [6:0]  r;
        logic        kp2;
        logic        xdiv2;
    } tune_plan_t;

    typedef enum logic [2:0] {
        S_IDLE, S_EVAL, S_WRITE, S_SETTLE, S_DONE, S_ERR
    } seq_state_t;

    function automatic logic [11:0] chan_to_mhz(input logic [3:0] ch);
        if (ch == 4'(CH_TOP))
            return 12'(CH_TOP_MHZ);
        return 12'(CH_BASE_MHZ) + 12'(CH_STEP_MHZ) * 12'(ch);
    endfunction

    function automatic wr_word_t pick_word(input logic [IDX_W-1:0] idx,
                                           input tune_plan_t p);
        wr_word_t w;
        case (idx)
            3'd0: begin w.addr = A_PWR;  w.data = PWR_WORD; end
            3'd1: begin w.addr = A_MAIN; w.data = DATA_W'(p.xdiv2) << MAIN_XDIV_BIT; end
            3'd2: begin w.addr = A_GAIN; w.data = DATA_W'(p.kp2) << GAIN_KP2_BIT; end
            3'd3: begin w.addr = A_IFN;  w.data = IFN_WORD; end
            3'd4: begin w.addr = A_IFR;  w.data = DATA_W'(p.r); end
            3'd5: begin w.addr = A_RF2R; w.data = DATA_W'(p.r); end
            default: begin w.addr = A_RF2N; w.data = DATA_W'(p.rf_n); end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/tune_plan_calc.sv
module tune_plan_calc
    import synth_tune_pkg::*;
(
    input  logic [3:0]  chan,
    input  logic        xdiv2,
    output tune_plan_t  plan
);
    localparam logic [6:0] R_HALVED = 7'(XIN_MHZ);
    localparam logic [6:0] R_DIRECT = 7'(2 * XIN_MHZ);

    logic [11:0] mhz;

    always_comb begin
        mhz        = chan_to_mhz(chan);
        plan.valid = (chan >= 4'd1) && (chan <= 4'(CH_TOP));
        plan.rf_n  = mhz - 12'(IF_MHZ);
        plan.kp2   = (plan.rf_n > 12'(KP2_LIMIT));
        plan.r     = xdiv2 ? R_HALVED : R_DIRECT;
        plan.xdiv2 = xdiv2;
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic fire
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CNT_W-1:0] cnt;
    logic             running;

    assign fire = running && (cnt == CNT_W'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (fire) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: the interval advances one step per cycle until it expires
    a_r8_count_steps: assert property (@(posedge clk) disable iff (rst)
        (running && !fire && !load) |=> (running && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tune_write_seq.sv
module tune_write_seq
    import synth_tune_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [3:0]  chan_i,
    input  logic        xdiv2_i,
    input  tune_plan_t  plan,
    input  logic        wr_ack_i,
    input  logic        settle_fire,
    output logic [3:0]  cfg_chan,
    output logic        cfg_xdiv2,
    output logic        settle_load,
    output logic        wr_req,
    output wr_word_t    word,
    output logic        busy,
    output logic        done,
    output logic        err
);
    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             last_word;

    assign wr_req      = (state == S_WRITE);
    assign word        = pick_word(idx, plan);
    assign last_word   = (idx == IDX_W'(NUM_WRITES - 1));
    assign settle_load = wr_req && wr_ack_i && last_word;
    assign busy        = (state != S_IDLE);
    assign done        = (state == S_DONE);
    assign err         = (state == S_ERR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            idx       <= '0;
            cfg_chan  <= '0;
            cfg_xdiv2 <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start_i) begin
                    cfg_chan  <= chan_i;
                    cfg_xdiv2 <= xdiv2_i;
                    state     <= S_EVAL;
                end
                S_EVAL: begin
                    idx   <= '0;
                    state <= plan.valid ? S_WRITE : S_ERR;
                end
                S_WRITE: if (wr_ack_i) begin
                    if (last_word) state <= S_SETTLE;
                    else           idx   <= idx + 1'b1;
                end
                S_SETTLE: if (settle_fire) state <= S_DONE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: done only follows the settling interval
    a_r8_done_after_settle: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state) == S_SETTLE);
    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11: busy falls only after a done or error pulse
    a_r11_busy_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done || err));
endmodule

// File: rtl/chan_tune_seq.sv
module chan_tune_seq
    import synth_tune_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int SETTLE_US = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [3:0]  chan_i,
    input  logic        xdiv2_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic        wr_req_o,
    output logic [3:0]  wr_addr_o,
    output logic [17:0] wr_data_o,
    input  logic        wr_ack_i
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

    tune_plan_t plan;
    wr_word_t   word;
    logic [3:0] cfg_chan;
    logic       cfg_xdiv2;
    logic       settle_load;
    logic       settle_fire;

    tune_plan_calc i_calc (
        .chan  (cfg_chan),
        .xdiv2 (cfg_xdiv2),
        .plan  (plan)
    );

    tune_write_seq i_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .chan_i      (chan_i),
        .xdiv2_i     (xdiv2_i),
        .plan        (plan),
        .wr_ack_i    (wr_ack_i),
        .settle_fire (settle_fire),
        .cfg_chan    (cfg_chan),
        .cfg_xdiv2   (cfg_xdiv2),
        .settle_load (settle_load),
        .wr_req      (wr_req_o),
        .word        (word),
        .busy        (busy_o),
        .done        (done_o),
        .err         (err_o)
    );

    settle_timer #(.CYCLES(SETTLE_CYC)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .load (settle_load),
        .fire (settle_fire)
    );

    assign wr_addr_o = word.addr;
    assign wr_data_o = word.data;

    // R2: the RF1 registers are never touched
    a_r2_no_rf1: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> (wr_addr_o != A_RF1N && wr_addr_o != A_RF1R));
    // R2: main follows power directly
    a_r2_order_head: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_ack_i && wr_addr_o == A_PWR) |=> (wr_req_o && wr_addr_o == A_MAIN));
    // R5: gain bit set from channel 3 upward
    a_r5_gain_bit: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_addr_o == A_GAIN) |-> (wr_data_o[GAIN_KP2_BIT] == (cfg_chan >= 4'd3)));
    // R7: an unacknowledged word is held
    a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));
    // R9: error excludes writes and done
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!wr_req_o && !done_o));
    // R10: captured configuration holds while busy
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(cfg_chan) && $stable(cfg_xdiv2)));
    // R11: no request while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !wr_req_o);
endmodule

// File: tb/test_chan_tune_seq.sv
module test_chan_tune_seq;
    localparam int CLK_MHZ   = 2;
    localparam int SETTLE_US = 100;
    localparam int SETTLE    = CLK_MHZ * SETTLE_US;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  chan_i = '0;
    logic        xdiv2_i = 1'b0;
    logic        busy_o, done_o, err_o, wr_req_o, wr_ack_i;
    logic [3:0]  wr_addr_o;
    logic [17:0] wr_data_o;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, wr_cnt = 0, done_cnt = 0, err_cnt = 0, done_gap = 0;
    int last_acc = 0, wait_n = 0, seed = 0, stab_bad = 0;
    bit have_prev = 0;
    logic [3:0]  prev_addr;
    logic [17:0] prev_data;
    logic [3:0]  log_addr [0:15];
    logic [17:0] log_data [0:15];

    always #5 clk = ~clk;

    chan_tune_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US)) i_chan_tune_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .xdiv2_i(xdiv2_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .wr_req_o(wr_req_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // downstream writer model with varying acknowledge delay
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            wr_ack_i = 1'b0;
        end else begin
            if (done_o) begin
                done_cnt++;
                if (done_cnt == 1) done_gap = cyc - last_acc;
            end
            if (err_o) err_cnt++;
            if (wr_ack_i) begin
                wr_ack_i = 1'b0;
            end else if (wr_req_o) begin
                if (have_prev && (wr_addr_o != prev_addr || wr_data_o != prev_data))
                    stab_bad++;
                prev_addr = wr_addr_o;
                prev_data = wr_data_o;
                have_prev = 1;
                if (wait_n >= (wr_cnt + seed) % 3) begin
                    wr_ack_i = 1'b1;
                    if (wr_cnt < 16) begin
                        log_addr[wr_cnt] = wr_addr_o;
                        log_data[wr_cnt] = wr_data_o;
                    end
                    wr_cnt++;
                    last_acc = cyc;
                    wait_n = 0;
                    have_prev = 0;
                end else begin
                    wait_n++;
                end
            end
        end
    end

    task automatic run_one(input int ch, input bit xd, input int inject_at);
        int mhz, n, r;
        bit valid;
        int exp_addr [0:6];
        int exp_data [0:6];
        wr_cnt = 0; done_cnt = 0; err_cnt = 0; stab_bad = 0; wait_n = 0;
        have_prev = 0; seed = ch + xd;
        valid = (ch >= 1 && ch <= 14);
        mhz = (ch == 14) ? 2484 : 2407 + 5 * ch;
        n = mhz - 374;
        r = xd ? 44 : 88;
        exp_addr = '{2, 0, 1, 5, 8, 7, 4};
        exp_data = '{3, xd ? 64 : 0, (n > 2047) ? 4 : 0, 1496, r, r, n};
        chan_i = 4'(ch); xdiv2_i = xd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
        for (int k = 0; k < SETTLE + 200 && busy_o; k++) begin
            if (inject_at >= 0 && wr_cnt == inject_at && !start_i) begin
                chan_i = 4'd11; xdiv2_i = ~xd; start_i = 1'b1;
                inject_at = -1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R11 busy low after run", busy_o, 0);
        chk(stab_bad == 0, "R7 word held until ack", stab_bad, 0);
        if (valid) begin
            chk(wr_cnt == 7, "R2/R10 write count", wr_cnt, 7);
            for (int i = 0; i < 7 && i < wr_cnt; i++) begin
                chk(log_addr[i] == 4'(exp_addr[i]), "R2 address order", log_addr[i], exp_addr[i]);
                case (i)
                    0, 3:    chk(log_data[i] == 18'(exp_data[i]), "R6 fixed word", log_data[i], exp_data[i]);
                    1, 4, 5: chk(log_data[i] == 18'(exp_data[i]), "R4 divider/mode word", log_data[i], exp_data[i]);
                    2:       chk(log_data[i] == 18'(exp_data[i]), "R5 gain word", log_data[i], exp_data[i]);
                    default: chk(log_data[i] == 18'(exp_data[i]), "R3 RF2 N word", log_data[i], exp_data[i]);
                endcase
            end
            chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
            chk(done_gap == SETTLE + 1, "R8 settle interval", done_gap, SETTLE + 1);
            chk(err_cnt == 0, "R9 no error on valid channel", err_cnt, 0);
        end else begin
            chk(err_cnt == 1, "R9 error pulse", err_cnt, 1);
            chk(wr_cnt == 0, "R9 no writes", wr_cnt, 0);
            chk(done_cnt == 0, "R9 no done", done_cnt, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !wr_req_o, "R1 reset state",
            {busy_o, done_o, err_o, wr_req_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !wr_req_o, "R1 idle after reset", {busy_o, wr_req_o}, 0);
        for (int xd = 0; xd < 2; xd++)
            for (int ch = 0; ch < 16; ch++)
                run_one(ch, xd[0], -1);
        // R10: start injected mid-sequence must not disturb channel 6
        run_one(6, 1'b0, 3);
        run_one(14, 1'b1, 6);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule